// File: doc/BRIEF.md
# SPI Panel Register Write Serializer

This block turns a single register write request into one 16-bit frame on a write-only, mode-0 SPI link to a display panel. A requester presents a 6-bit register address and an 8-bit value with `req_valid`. The block takes them on a clock edge where `req_ready` is high and captures them in a shift register. It then drives chip select low, sends the 16 bits most significant first on the serial clock and data lines, and releases chip select. A short idle gap follows, and only after it does `req_ready` rise again. There is no read-back path: the panel is only written.

The frame is laid out as follows:
- Bits 15:10 hold the address.
- Bit 9 is 0.
- Bit 8 is 1 and marks a write.
- Bits 7:0 hold the data.

One parameter, `HALF_DIV`, sets how many system clocks each half of a serial clock period lasts. Every phase of the transfer (lead-in, each half bit, hold, gap) lasts exactly that long.

Control is a six-state machine:
- `ST_IDLE` moves to `ST_SETUP` when a request is accepted.
- `ST_SETUP` is the chip-select lead-in. It moves to `ST_HIGH` after one half period.
- `ST_HIGH` is the clock-high phase. It moves to `ST_LOW` while bits remain, or to `ST_HOLD` after the sixteenth bit.
- `ST_LOW` is the clock-low phase. It moves back to `ST_HIGH`.
- `ST_HOLD` keeps chip select low and moves to `ST_GAP`.
- `ST_GAP` has chip select high and moves back to `ST_IDLE`.

Top module: `spi_panel_wr`

## Requirements
- R1: Each accepted request produces exactly one chip-select low window containing exactly 16 rising edges of `spi_sclk`.
- R2: `spi_sclk` is low whenever chip select is high. `spi_mosi` never changes while `spi_sclk` is high, so it is stable at every rising edge (SPI mode 0).
- R3: The first six bits sent, at frame bits 15:10, are the accepted address, most significant bit first.
- R4: The next two bits sent are 0 then 1 (frame bit 9 = 0, frame bit 8 = 1).
- R5: The last eight bits sent, at frame bits 7:0, are the accepted data byte, most significant bit first.
- R6: Chip select falls exactly `HALF_DIV` system clocks before the first rising edge of `spi_sclk`. It rises exactly `HALF_DIV` clocks after the last falling edge of `spi_sclk`.
- R7: Every high phase of `spi_sclk` lasts exactly `HALF_DIV` system clocks.
- R8: `req_ready` goes low in the cycle after a request is accepted. It stays low until `HALF_DIV` clocks after chip select rises. A request presented while `req_ready` is low is held off and is sent once it is accepted, never lost.
- R9: During and right after reset, `spi_cs_n` is high, `spi_sclk` and `spi_mosi` are low, and `req_ready` is high.
- R10: Address and data are captured at acceptance. Changing `req_addr` or `req_data` during a transfer has no effect on the bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | 6 | Panel register address |
| req_data | input | 8 | Register value |
| req_ready | output | 1 | Block idle and able to accept a request |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the panel |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
A wrong state or a stray shift shows up at the frame boundary. The frame gets the wrong number of rising edges, or the decoded address, flag or data field is wrong. This is seen no later than the chip-select rise that ends that frame. A miscounting pacer shows up within one half period as a lead-in, high phase or hold of the wrong length. A machine that leaves idle too early, or returns to it too early, shows up as `req_ready` rising at the wrong distance from chip select. It also shows up as a held-off request whose frame goes missing from the expected queue.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_HOLD  = 3'd4,
        ST_GAP   = 3'd5
    } wr_state_t;

    // bits 9:8 of the frame: zero then the write marker
    localparam logic [1:0] WR_MARK = 2'b01;

endpackage

// File: rtl/spi_wr_pack.sv
module spi_wr_pack #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    localparam int FRAME_W = ADDR_W + 2 + DATA_W
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  data,
    output logic [FRAME_W-1:0] frame
);
    import spi_wr_pkg::*;

    always_comb begin
        frame = {addr, WR_MARK, data};
    end

endmodule

// File: rtl/spi_wr_pace.sv
module spi_wr_pace #(
    parameter int HALF_DIV = 4,
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == CW'(HALF_DIV - 1));
    assign tick   = run && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (HALF_DIV > 1) begin : g_gap_chk
            // R7: phase ticks never come back to back when a half period spans several clocks
            p_tick_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("pacer ticked on consecutive cycles");
        end
    endgenerate

endmodule

// File: rtl/spi_wr_fsm.sv
module spi_wr_fsm #(
    parameter int FRAME_W = 16,
    localparam int CNT_W = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               tick,
    output logic               idle,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n
);
    import spi_wr_pkg::*;

    wr_state_t         st, st_nx;
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   sent;
    logic               last_bit;

    assign last_bit = (sent == CNT_W'(FRAME_W - 1));

    // next-state decode
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start) st_nx = ST_SETUP;
            ST_SETUP: if (tick)  st_nx = ST_HIGH;
            ST_HIGH:  if (tick)  st_nx = last_bit ? ST_HOLD : ST_LOW;
            ST_LOW:   if (tick)  st_nx = ST_HIGH;
            ST_HOLD:  if (tick)  st_nx = ST_GAP;
            ST_GAP:   if (tick)  st_nx = ST_IDLE;
            default:             st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // frame shifter: advances on the high-to-low transition except after the final bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            sent <= '0;
        end else if (start && st == ST_IDLE) begin
            sh   <= frame_in;
            sent <= '0;
        end else if (tick && st == ST_HIGH) begin
            sent <= sent + 1'b1;
            if (!last_bit) begin
                sh <= sh << 1;
            end
        end
    end

    // output decode
    always_comb begin
        idle = (st == ST_IDLE);
        sclk = (st == ST_HIGH);
        cs_n = (st == ST_IDLE) || (st == ST_GAP);
        mosi = cs_n ? 1'b0 : sh[FRAME_W-1];
    end

    // R2: data held steady through each clock-high phase
    p_mosi_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi))
        else $error("mosi moved while sclk high");

    // R6: a rising serial clock edge is always preceded by chip select already low
    p_cs_leads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (!cs_n && !$past(cs_n)))
        else $error("sclk rose without chip-select lead");

    // R6: chip select only releases from a clock-low state
    p_cs_release_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (!sclk && !$past(sclk)))
        else $error("chip select rose next to a high clock");

endmodule

// File: rtl/spi_panel_wr.sv
module spi_panel_wr #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_cs_n
);
    localparam int FRAME_W = ADDR_W + 2 + DATA_W;
    localparam int RC_W    = $clog2(FRAME_W + 1) + 1;

    logic [FRAME_W-1:0] frame;
    logic               idle;
    logic               tick;
    logic               take;

    assign take      = req_valid && idle;
    assign req_ready = idle;

    spi_wr_pack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pack (
        .addr  (req_addr),
        .data  (req_data),
        .frame (frame)
    );

    spi_wr_pace #(.HALF_DIV(HALF_DIV)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!idle),
        .tick  (tick)
    );

    spi_wr_fsm #(.FRAME_W(FRAME_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (take),
        .frame_in (frame),
        .tick     (tick),
        .idle     (idle),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .cs_n     (spi_cs_n)
    );

    // rising-edge tally per chip-select window, used only by the checks below
    logic            sclk_q;
    logic [RC_W-1:0] rises;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            rises  <= '0;
        end else begin
            sclk_q <= spi_sclk;
            if (spi_cs_n) begin
                rises <= '0;
            end else if (spi_sclk && !sclk_q) begin
                rises <= rises + 1'b1;
            end
        end
    end

    // R1: one full frame of clock edges per window
    p_frame_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (rises == RC_W'(FRAME_W)))
        else $error("wrong number of sclk edges in frame");

    // R8: acceptance drops ready on the next cycle
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready)
        else $error("ready stayed high after acceptance");

    // R9: idle lines quiet while ready
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (spi_cs_n && !spi_sclk && !spi_mosi))
        else $error("serial lines active while idle");

endmodule

// File: tb/spi_panel_wr_tb.sv
`timescale 1ns/1ps
module spi_panel_wr_tb;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [5:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       req_ready, spi_sclk, spi_mosi, spi_cs_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] exp_q[$];

    spi_panel_wr #(.ADDR_W(6), .DATA_W(8), .HALF_DIV(H)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .req_ready (req_ready),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_cs_n  (spi_cs_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor state
    bit          mon_on = 0;
    logic        p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0;
    logic [15:0] got;
    int nrise, lead, hi_len, after_fall, gap;
    bit in_gap = 0;

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (spi_cs_n && spi_sclk) chk(0, "R2 sclk high while cs high", 1, 0);
            if (spi_sclk && p_sclk && spi_mosi !== p_mosi)
                chk(0, "R2 mosi changed in high phase", int'(spi_mosi), int'(p_mosi));
            if (p_cs && !spi_cs_n) begin
                got = '0; nrise = 0; lead = 0; hi_len = 0; after_fall = 0;
            end else if (!spi_cs_n) begin
                lead++;
                after_fall++;
                if (spi_sclk && !p_sclk) begin
                    if (nrise == 0) chk(lead == H, "R6 lead-in length", lead, H);
                    got = {got[14:0], spi_mosi};
                    nrise++;
                    hi_len = 1;
                end else if (spi_sclk && p_sclk) begin
                    hi_len++;
                end else if (!spi_sclk && p_sclk) begin
                    chk(hi_len == H, "R7 high phase length", hi_len, H);
                    after_fall = 0;
                end
            end else if (!p_cs && spi_cs_n) begin
                after_fall++;
                chk(nrise == 16, "R1 rising edges per frame", nrise, 16);
                chk(after_fall == H, "R6 hold after last fall", after_fall, H);
                chk(!req_ready, "R8 ready low at cs release", int'(req_ready), 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R1 frame with no request", int'(got), 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(got[15:10] == e[15:10], "R3 R10 address field", int'(got[15:10]), int'(e[15:10]));
                    chk(got[9:8] == 2'b01, "R4 flag bits", int'(got[9:8]), 1);
                    chk(got[7:0] == e[7:0], "R5 R10 data field", int'(got[7:0]), int'(e[7:0]));
                end
                gap = 0; in_gap = 1;
            end
            if (in_gap && spi_cs_n && !(!p_cs && spi_cs_n)) begin
                gap++;
                if (req_ready) begin
                    chk(gap == H, "R8 ready return after cs", gap, H);
                    in_gap = 0;
                end
            end
        end
        p_cs = spi_cs_n; p_sclk = spi_sclk; p_mosi = spi_mosi;
    end

    // driver: push expected, hold request until taken, then scramble inputs (R10)
    task automatic send(input logic [5:0] a, input logic [7:0] d);
        bit acc;
        req_valid = 1'b1; req_addr = a; req_data = d;
        exp_q.push_back({a, 2'b01, d});
        do begin
            acc = req_ready;
            @(negedge clk);
        end while (!acc);
        chk(!req_ready, "R8 ready low after accept", int'(req_ready), 0);
        req_valid = 1'b0; req_addr = ~a; req_data = ~d;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || !req_ready || in_gap) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        req_valid = 1'b1; req_addr = 6'h3F; req_data = 8'hFF;
        repeat (4) @(negedge clk);
        // R9 during reset, with a request pending
        chk(spi_cs_n === 1'b1, "R9 cs_n in reset", int'(spi_cs_n), 1);
        chk(spi_sclk === 1'b0, "R9 sclk in reset", int'(spi_sclk), 0);
        chk(spi_mosi === 1'b0, "R9 mosi in reset", int'(spi_mosi), 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R9 ready after reset", int'(req_ready), 1);
        chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R9 lines idle after reset",
            int'({spi_cs_n, spi_sclk}), 2);
        mon_on = 1;

        send(6'h00, 8'h00); drain();
        send(6'h3F, 8'hFF); drain();
        send(6'h02, 8'h0F); drain();
        send(6'h15, 8'hA5); drain();
        send(6'h2A, 8'h5A); drain();
        // back-to-back: each later request is presented while busy and held off (R8)
        send(6'h11, 8'h6A);
        send(6'h20, 8'hF0);
        send(6'h21, 8'hF0);
        send(6'h04, 8'h17);
        send(6'h14, 8'h01);
        drain();
        // idle stretch: no frame may appear without a request (R1)
        repeat (50) @(negedge clk);
        chk(spi_cs_n === 1'b1, "R1 no spontaneous frame", int'(spi_cs_n), 1);
        chk(exp_q.size() == 0, "R8 all held requests sent", exp_q.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule